// File: doc/BRIEF.md
# Queued interprocessor mailbox

This block lets two processors pass 32-bit messages to each other through two hardware queues. Each queue is a four-entry first-in first-out buffer. Both processors reach it over one shared single-cycle register bus: writing a queue's message register appends a word, and reading it removes the oldest word. Each queue also has a read-only level register that reports how many words it holds and whether it is full.

Each processor (a "user") has its own interrupt line and its own set of status bits. Every queue produces two events: a new-message event while the queue holds data, and a not-full event while it has room. A user takes the receiver role on a queue by enabling that queue's new-message event. It takes the sender role by enabling the not-full event. The hardware fixes neither role. Status bits are cleared by writing a 1 to them. An idle output tells the power logic when the block has no bus access in progress and no interrupt pending.

Top module: `ipc_mailbox`

## Requirements
- R1: Each of the two queues returns its words in the order they were written, holds up to four words, and is independent of the other queue.
- R2: A message write to a full queue is dropped, and the queue's count and contents stay unchanged.
- R3: A message read from an empty queue returns zero and leaves the count at zero.
- R4: The level register of queue q (word address 4+q) reports the word count in bits [2:0] and a full flag in bit 4. All other bits read zero.
- R5: In each user's raw status word (word address 8+u), bit 2q is the new-message bit for queue q. It becomes 1 when a word is written to that queue and stays 1 while the queue is non-empty, even if a 1 is written to clear it. Once the queue is empty, writing a 1 clears it.
- R6: In the raw status word, bit 2q+1 is the not-full bit for queue q. It is forced to 1 while the queue has room. Once the queue is full it keeps its value until a 1 is written to it.
- R7: Each user's enable word (word address 16+u, read/write, same bit layout as the raw status) selects which raw bits appear in its enabled status word (word address 12+u). The user's interrupt line is high exactly when any enabled status bit is 1.
- R8: Writing a word to either the raw or the enabled status address of user u clears the raw bits of user u where the written word has 1s. Bits written as 0 are unaffected, and the other user's status is untouched.
- R9: The idle output is 1 only when the bus is not selected and both interrupt lines are low.
- R10: A synchronous reset empties both queues and clears all enable bits and all status bits. The interrupt lines are low right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address: bits [4:2] select the register group, bits [1:0] the queue or user |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 2 | One interrupt line per user |
| idle_ok | output | 1 | The block may be idled |

## Verification
The bench builds the block with its default parameters: two queues four words deep, 32-bit data and two users. Filling a queue therefore takes only four writes, so the full boundary, the dropped write and the status bit that stays set on a full queue are all reached directly. Every bit of both users' status, enable and enabled-status words is visible through the register map. This lets the bench set up one user as receiver and the other as sender on the same queue, and watch both interrupt lines as the queue moves between empty, partly filled and full.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

    // Address split: group in the upper bits, queue/user index in the lower bits
    localparam int GRP_W    = 3;
    localparam int IDX_W    = 2;
    localparam int ADDR_W   = GRP_W + IDX_W;
    // Position of the full flag inside a level word
    localparam int FULL_BIT = 4;

    typedef enum logic [GRP_W-1:0] {
        G_MSG = 3'd0,   // queue data port
        G_LVL = 3'd1,   // queue level (count and full)
        G_RAW = 3'd2,   // per-user raw status, write-one-to-clear
        G_MSK = 3'd3,   // per-user enabled status, write-one-to-clear
        G_EN  = 3'd4    // per-user event enable
    } grp_e;

    typedef struct packed {
        logic             rd;
        logic             wr;
        grp_e             grp;
        logic [IDX_W-1:0] idx;
    } acc_t;

    function automatic acc_t decode_access(input logic sel,
                                           input logic wr,
                                           input logic [ADDR_W-1:0] addr);
        acc_t a;
        a.rd  = sel & ~wr;
        a.wr  = sel & wr;
        a.grp = grp_e'(addr[ADDR_W-1:IDX_W]);
        a.idx = addr[IDX_W-1:0];
        return a;
    endfunction

    // Status word layout: two bits per queue
    function automatic int nm_bit(input int q);
        return 2 * q;
    endfunction

    function automatic int nf_bit(input int q);
        return 2 * q + 1;
    endfunction

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wp, rp;
    logic [CNT_W-1:0]  cnt;
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == CNT_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign head    = mem[rp];
    assign count   = cnt;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R2: occupancy never exceeds the depth
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH));

    // R2: a write into a full queue leaves it full and the write pointer still
    p_drop_full_r2: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == CNT_W'(DEPTH)) && $stable(wp));

    // R3: a read from an empty queue leaves it empty
    p_empty_read_r3: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (count == '0) && $stable(rp));

endmodule

// File: rtl/mbox_user_irq.sv
module mbox_user_irq
    import ipc_mbox_pkg::*;
#(
    parameter int NUM_Q = 2,
    localparam int SW   = 2 * NUM_Q
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_we,
    input  logic [SW-1:0]    en_wdata,
    input  logic [SW-1:0]    clr,
    input  logic [NUM_Q-1:0] q_nz,
    input  logic [NUM_Q-1:0] q_full,
    input  logic [NUM_Q-1:0] q_push,
    output logic [SW-1:0]    raw,
    output logic [SW-1:0]    en,
    output logic [SW-1:0]    masked,
    output logic             irq
);

    logic [SW-1:0] raw_nx;

    generate
        for (genvar q = 0; q < NUM_Q; q++) begin : g_q
            localparam int NM = 2 * q;
            localparam int NF = 2 * q + 1;

            // New-message: level while data present, sticky until cleared on empty
            always_comb begin
                if (q_nz[q] || q_push[q])   raw_nx[NM] = 1'b1;
                else if (clr[NM])           raw_nx[NM] = 1'b0;
                else                        raw_nx[NM] = raw[NM];
            end

            // Not-full: level while room exists, sticky until cleared when full
            always_comb begin
                if (!q_full[q])             raw_nx[NF] = 1'b1;
                else if (clr[NF])           raw_nx[NF] = 1'b0;
                else                        raw_nx[NF] = raw[NF];
            end

            // R5: a non-empty queue keeps its new-message bit set
            p_newmsg_hold_r5: assert property (@(posedge clk) disable iff (rst)
                q_nz[q] |=> raw[nm_bit(q)]);

            // R6: a queue with room keeps its not-full bit set
            p_notfull_hold_r6: assert property (@(posedge clk) disable iff (rst)
                !q_full[q] |=> raw[nf_bit(q)]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            raw <= '0;
            en  <= '0;
        end else begin
            raw <= raw_nx;
            if (en_we) en <= en_wdata;
        end
    end

    assign masked = raw & en;
    assign irq    = |masked;

    // R7: a disabled user never interrupts
    p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !irq);

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mbox_pkg::*;
#(
    parameter int NUM_Q     = 2,
    parameter int NUM_USERS = 2,
    parameter int DATA_W    = 32,
    parameter int DEPTH     = 4,
    localparam int SW       = 2 * NUM_Q,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_USERS-1:0] irq,
    output logic                 idle_ok
);

    acc_t acc;
    assign acc = decode_access(bus_sel, bus_wr, bus_addr);

    // Queue side
    logic [DATA_W-1:0] q_head [NUM_Q];
    logic [CNT_W-1:0]  q_cnt  [NUM_Q];
    logic [NUM_Q-1:0]  q_full, q_empty, q_push, q_pop;

    generate
        for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
            assign q_push[q] = acc.wr && acc.grp == G_MSG && acc.idx == IDX_W'(q);
            assign q_pop[q]  = acc.rd && acc.grp == G_MSG && acc.idx == IDX_W'(q);

            mbox_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
                .clk   (clk),
                .rst   (rst),
                .push  (q_push[q]),
                .pop   (q_pop[q]),
                .wdata (bus_wdata),
                .head  (q_head[q]),
                .count (q_cnt[q]),
                .full  (q_full[q]),
                .empty (q_empty[q])
            );

            // R3: reading an empty queue's data port yields zero
            p_rdata_empty_r3: assert property (@(posedge clk) disable iff (rst)
                (q_pop[q] && q_cnt[q] == '0) |-> (bus_rdata == '0));
        end
    endgenerate

    // User side
    logic [SW-1:0] u_raw [NUM_USERS];
    logic [SW-1:0] u_en  [NUM_USERS];
    logic [SW-1:0] u_msk [NUM_USERS];

    generate
        for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
            logic          hit, en_we;
            logic [SW-1:0] clr;

            assign hit   = acc.wr && acc.idx == IDX_W'(u);
            assign en_we = hit && acc.grp == G_EN;
            assign clr   = (hit && (acc.grp == G_RAW || acc.grp == G_MSK))
                           ? bus_wdata[SW-1:0] : '0;

            mbox_user_irq #(.NUM_Q(NUM_Q)) u_irq (
                .clk      (clk),
                .rst      (rst),
                .en_we    (en_we),
                .en_wdata (bus_wdata[SW-1:0]),
                .clr      (clr),
                .q_nz     (~q_empty),
                .q_full   (q_full),
                .q_push   (q_push),
                .raw      (u_raw[u]),
                .en       (u_en[u]),
                .masked   (u_msk[u]),
                .irq      (irq[u])
            );
        end
    endgenerate

    // Read data mux
    always_comb begin
        bus_rdata = '0;
        if (acc.rd) begin
            for (int q = 0; q < NUM_Q; q++) begin
                if (acc.idx == IDX_W'(q)) begin
                    if (acc.grp == G_MSG && !q_empty[q])
                        bus_rdata = q_head[q];
                    else if (acc.grp == G_LVL)
                        bus_rdata = DATA_W'(q_cnt[q])
                                  | (DATA_W'(q_full[q]) << FULL_BIT);
                end
            end
            for (int u = 0; u < NUM_USERS; u++) begin
                if (acc.idx == IDX_W'(u)) begin
                    if (acc.grp == G_RAW) bus_rdata = DATA_W'(u_raw[u]);
                    else if (acc.grp == G_MSK) bus_rdata = DATA_W'(u_msk[u]);
                    else if (acc.grp == G_EN)  bus_rdata = DATA_W'(u_en[u]);
                end
            end
        end
    end

    assign idle_ok = !bus_sel && (irq == '0);

    // R9: a bus access in progress keeps the block awake
    p_busy_not_idle_r9: assert property (@(posedge clk) disable iff (rst)
        bus_sel |-> !idle_ok);

    // R9: a pending interrupt keeps the block awake
    p_irq_not_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (irq != '0) |-> !idle_ok);

endmodule

// File: tb/ipc_mailbox_test.sv
module ipc_mailbox_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        wr  = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;
    logic        idle_ok;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ipc_mailbox uut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (sel),
        .bus_wr    (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq),
        .idle_ok   (idle_ok)
    );

    localparam logic [4:0] A_MSG = 5'd0, A_LVL = 5'd4, A_RAW = 5'd8,
                           A_MSK = 5'd12, A_EN = 5'd16;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        settle();
        check("R10 irq after reset", {30'd0, irq}, 32'd0);
        check("R9 idle after reset", {31'd0, idle_ok}, 32'd1);
        bus_read(A_LVL + 0, d); check("R10 level q0", d, 32'd0);
        bus_read(A_LVL + 1, d); check("R10 level q1", d, 32'd0);
        bus_read(A_EN + 0, d);  check("R10 enable u0", d, 32'd0);
        bus_read(A_EN + 1, d);  check("R10 enable u1", d, 32'd0);
        bus_read(A_RAW + 0, d); check("R10 newmsg bits u0", d & 32'h5, 32'd0);
    endtask

    task automatic t_fifo_order();
        logic [31:0] d;
        for (int i = 0; i < 4; i++) bus_write(A_MSG + 0, 32'hA000_0000 + i);
        bus_read(A_LVL + 0, d); check("R4 level q0 full", d, 32'h14);
        bus_write(A_MSG + 1, 32'h1234_5678);
        bus_read(A_LVL + 1, d); check("R1 level q1 independent", d, 32'h1);
        for (int i = 0; i < 4; i++) begin
            bus_read(A_MSG + 0, d); check("R1 q0 order", d, 32'hA000_0000 + i);
        end
        bus_read(A_LVL + 0, d); check("R4 level q0 drained", d, 32'h0);
        bus_read(A_MSG + 1, d); check("R1 q1 data", d, 32'h1234_5678);
    endtask

    task automatic t_full_drop();
        logic [31:0] d;
        for (int i = 0; i < 4; i++) bus_write(A_MSG + 1, 32'hB0 + i);
        bus_write(A_MSG + 1, 32'hDEAD_BEEF);
        bus_read(A_LVL + 1, d); check("R2 level after dropped write", d, 32'h14);
        for (int i = 0; i < 4; i++) begin
            bus_read(A_MSG + 1, d); check("R2 contents unchanged", d, 32'hB0 + i);
        end
        bus_read(A_LVL + 1, d); check("R2 drained", d, 32'h0);
    endtask

    task automatic t_empty_read();
        logic [31:0] d;
        bus_read(A_MSG + 0, d); check("R3 empty read value", d, 32'h0);
        bus_read(A_LVL + 0, d); check("R3 count stays zero", d, 32'h0);
    endtask

    task automatic t_newmsg();
        logic [31:0] d;
        bus_write(A_RAW + 0, 32'hF);
        bus_read(A_RAW + 0, d); check("R5 cleared newmsg, notfull kept", d, 32'hA);
        bus_read(A_RAW + 1, d); check("R8 other user untouched", d, 32'hF);
        bus_write(A_MSG + 0, 32'h55);
        bus_read(A_RAW + 0, d); check("R5 newmsg set on write", d, 32'hB);
        bus_write(A_RAW + 0, 32'h1);
        bus_read(A_RAW + 0, d); check("R5 clear ignored while non-empty", d, 32'hB);
        bus_read(A_MSG + 0, d); check("R1 single word", d, 32'h55);
        bus_write(A_RAW + 0, 32'h1);
        bus_read(A_RAW + 0, d); check("R5 clear once empty", d, 32'hA);
    endtask

    task automatic t_notfull();
        logic [31:0] d;
        for (int i = 0; i < 4; i++) bus_write(A_MSG + 0, 32'hC0 + i);
        bus_read(A_RAW + 0, d); check("R6 notfull held when full", d, 32'hB);
        bus_write(A_RAW + 0, 32'h2);
        bus_read(A_RAW + 0, d); check("R6 notfull cleared when full", d, 32'h9);
        bus_read(A_MSG + 0, d); check("R1 head after fill", d, 32'hC0);
        settle();
        bus_read(A_RAW + 0, d); check("R6 notfull back after space", d, 32'hB);
        for (int i = 1; i < 4; i++) bus_read(A_MSG + 0, d);
        check("R1 last word", d, 32'hC3);
    endtask

    task automatic t_irq_roles();
        logic [31:0] d;
        bus_write(A_RAW + 0, 32'hF);
        bus_write(A_RAW + 1, 32'hF);
        bus_write(A_EN + 0, 32'h1);
        bus_write(A_EN + 1, 32'h2);
        bus_read(A_EN + 1, d); check("R7 enable readback", d, 32'h2);
        settle();
        check("R7 sender irq only", {30'd0, irq}, 32'h2);
        check("R9 not idle with irq", {31'd0, idle_ok}, 32'd0);
        bus_read(A_MSK + 1, d); check("R7 enabled status u1", d, 32'h2);
        bus_read(A_MSK + 0, d); check("R7 enabled status u0", d, 32'h0);
        bus_write(A_MSG + 0, 32'h77);
        settle();
        check("R7 receiver irq on message", {30'd0, irq}, 32'h3);
        for (int i = 1; i < 4; i++) bus_write(A_MSG + 0, 32'h77 + i);
        bus_write(A_MSK + 1, 32'h2);
        settle();
        check("R8 masked clear drops sender irq", {30'd0, irq}, 32'h1);
        bus_read(A_MSG + 0, d);
        settle();
        check("R6 sender irq on space", {30'd0, irq}, 32'h3);
        for (int i = 1; i < 4; i++) bus_read(A_MSG + 0, d);
        bus_write(A_RAW + 0, 32'h1);
        settle();
        check("R5 receiver irq cleared", {30'd0, irq}, 32'h2);
        bus_write(A_EN + 1, 32'h0);
        settle();
        check("R9 idle when quiet", {31'd0, idle_ok}, 32'd1);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = A_LVL;
        #1 check("R9 not idle during access", {31'd0, idle_ok}, 32'd0);
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic t_mid_reset();
        logic [31:0] d;
        bus_write(A_MSG + 1, 32'h11);
        bus_write(A_MSG + 1, 32'h22);
        bus_write(A_EN + 0, 32'h3);
        settle();
        check("R7 irq before reset", {30'd0, irq}, 32'h1);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        #1 check("R10 irq after mid reset", {30'd0, irq}, 32'h0);
        bus_read(A_LVL + 1, d); check("R10 queue emptied", d, 32'h0);
        bus_read(A_EN + 0, d);  check("R10 enable cleared", d, 32'h0);
        bus_read(A_MSG + 1, d); check("R10 no stale data", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fifo_order();
        t_full_drop();
        t_empty_read();
        t_newmsg();
        t_notfull();
        t_irq_roles();
        t_mid_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule